// File: doc/BRIEF.md
# Two-Phase Stepper Phase Sequencer

This block produces the four low-side gate enables of a unipolar two-phase stepping motor: phase A, its complement A-not, phase B and its complement B-not. Each rising edge of an external step clock moves the motor one position. The motor speed therefore follows the frequency of that clock. A mode input selects full-step drive, in which two windings are always on, or half-step drive, which inserts a single-winding state between each pair. A direction input picks the order in which the positions are visited.

Every control input is asynchronous to the fast system clock. Each one passes through a two-flop synchroniser before it is used. The current position is an index into eight half-step states. Full-step drive uses only the four even (two-winding) states. Asserting reset turns every gate off at once and returns the index to its home state. Dropping the run enable also turns every gate off, but the index is kept, so when the enable returns stepping resumes from the same excitation position. Current chopping and the power stage sit outside the block.

Top module: `stepper_phase_seq`

## Requirements
- R1: The position moves exactly once per rising edge of `stepIn`. A raw rising edge between two clock edges shows on the gate outputs after the third following rising edge of `clk`. A falling edge of `stepIn`, or holding it at one level, never moves the position.
- R2: The gate pattern {gateA, gateAn, gateB, gateBn} for state index 0 to 7 is 1001, 1000, 1010, 0010, 0110, 0100, 0101, 0001. Forward stepping visits the states in increasing index order.
- R3: With `modeHalf` low (full-step), each step from an even state moves the index by two. Only the two-winding states 0, 2, 4 and 6 are then visited.
- R4: With `modeHalf` high (half-step), each step moves the index by one.
- R5: `dirCcw` low steps forward (index increases). `dirCcw` high steps in reverse (index decreases). The index wraps modulo 8 in both directions.
- R6: The mode is sampled at the step edge. If full-step is selected while the index is odd, that step moves the index by one, so the sequencer lands on a two-winding state.
- R7: A low `rstN` turns all four gates off within the same clock period. Once `rstN` is high again and the enable is high, the gates show state 0 (A with B-not).
- R8: A low `runEn` turns all four gates off within two clock edges. Step edges that arrive while it is low are discarded. When it is raised again, the gates show the same state as before it fell.
- R9: gateA and gateAn are never on together, and gateB and gateBn are never on together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| stepIn | input | 1 | Asynchronous step clock; each rising edge advances one position |
| modeHalf | input | 1 | Asynchronous; 0 selects full-step, 1 selects half-step |
| dirCcw | input | 1 | Asynchronous; 0 steps forward, 1 steps in reverse |
| rstN | input | 1 | Asynchronous active-low reset; gates off, index to home |
| runEn | input | 1 | Asynchronous; 0 forces gates off and freezes the index |
| gateA | output | 1 | Low-side enable for winding A |
| gateAn | output | 1 | Low-side enable for winding A-not |
| gateB | output | 1 | Low-side enable for winding B |
| gateBn | output | 1 | Low-side enable for winding B-not |

## Verification
A mode change and a step can fall in the same cycle. When full-step is selected while the index sits on an odd, single-winding state, the step that samples the new mode must move by one instead of two. The bench provokes this by walking half-step onto an odd state and then issuing a full-step move in each direction. It judges the result from the gate pattern against the state table. A second collision is a step edge arriving while the enable is low. The bench pulses the step input during the disabled window and then checks that the restored pattern equals the one seen before the enable dropped.

// File: rtl/sps_pkg.sv
package sps_pkg;
  localparam int POS_W = 3;
  localparam int GATE_W = 4;

  typedef logic [POS_W-1:0] pos_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;    // return index to home
    logic advance;  // move the index this cycle
    logic reverse;  // decrement instead of increment
    logic stepTwo;  // move by two states instead of one
    logic drive;    // gates may be on
  } seq_strobe_t;
endpackage

// File: rtl/sps_sync.sv
module sps_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) stg[0] <= d;

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) stg[i] <= stg[i-1];
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sps_rst_sync.sv
module sps_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  output logic rstActive
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rstActive = ~chain[STAGES-1];
endmodule

// File: rtl/sps_ctrl.sv
module sps_ctrl
  import sps_pkg::*;
(
  input  logic        clk,
  input  logic        rstActive,
  input  logic        stepS,
  input  logic        modeS,
  input  logic        dirS,
  input  logic        enS,
  input  logic        posOdd,
  output seq_strobe_t st
);
  logic stepPrev;
  logic stepRise;

  // tracks the synchronised step level at all times, so a level held
  // through reset or a disabled window never yields a late edge
  always_ff @(posedge clk) stepPrev <= stepS;

  assign stepRise = stepS & ~stepPrev;

  always_comb begin
    st.clear   = rstActive;
    st.drive   = ~rstActive & enS;
    st.advance = stepRise & ~rstActive & enS;
    st.reverse = dirS;
    // full-step from an odd state moves by one to reach a paired state
    st.stepTwo = ~modeS & ~posOdd;
  end

  AST_ONE_MOVE_PER_EDGE: assert property (@(posedge clk) disable iff (rstActive)
    st.advance |=> !st.advance); // R1
  AST_FULL_LANDS_PAIRED: assert property (@(posedge clk) disable iff (rstActive)
    (st.advance && !modeS) |=> !posOdd); // R6
  AST_HALF_MOVES_ONE: assert property (@(posedge clk) disable iff (rstActive)
    (st.advance && modeS) |=> (posOdd != $past(posOdd))); // R4
endmodule

// File: rtl/sps_datapath.sv
module sps_datapath
  import sps_pkg::*;
(
  input  logic        clk,
  input  seq_strobe_t st,
  output logic        posOdd,
  output logic [GATE_W-1:0] gates
);
  pos_t pos;
  pos_t delta;

  assign delta = st.stepTwo ? pos_t'(2) : pos_t'(1);

  always_ff @(posedge clk) begin
    if (st.clear)        pos <= '0;
    else if (st.advance) pos <= st.reverse ? pos - delta : pos + delta;
  end

  assign posOdd = pos[0];

  // {A, A-not, B, B-not}
  function automatic logic [GATE_W-1:0] decode(input pos_t p);
    logic onA, onAn, onB, onBn;
    onA  = (p == 3'd7) ? 1'b0 : (p <= 3'd2);
    onB  = (p >= 3'd2) && (p <= 3'd4);
    onAn = (p >= 3'd4) && (p <= 3'd6);
    onBn = (p >= 3'd6) || (p == 3'd0);
    return {onA, onAn, onB, onBn};
  endfunction

  assign gates = st.drive ? decode(pos) : '0;

  AST_PHASE_EXCLUSIVE: assert property (@(posedge clk) disable iff (st.clear)
    !(gates[3] && gates[2]) && !(gates[1] && gates[0])); // R9
  AST_POS_HOLDS_IDLE: assert property (@(posedge clk) disable iff (st.clear)
    !st.advance |=> $stable(pos)); // R8
endmodule

// File: rtl/stepper_phase_seq.sv
module stepper_phase_seq
  import sps_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic stepIn,
  input  logic modeHalf,
  input  logic dirCcw,
  input  logic rstN,
  input  logic runEn,
  output logic gateA,
  output logic gateAn,
  output logic gateB,
  output logic gateBn
);
  localparam int N_ASYNC = 4;

  logic [N_ASYNC-1:0] rawIn;
  logic [N_ASYNC-1:0] syncIn;
  logic               rstActive;
  logic               posOdd;
  logic [GATE_W-1:0]  gates;
  seq_strobe_t        st;

  assign rawIn = {stepIn, modeHalf, dirCcw, runEn};

  sps_sync #(.STAGES(SYNC_STAGES), .WIDTH(N_ASYNC)) u_sync (
    .clk (clk),
    .d   (rawIn),
    .q   (syncIn)
  );

  sps_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rstN      (rstN),
    .rstActive (rstActive)
  );

  sps_ctrl u_ctrl (
    .clk       (clk),
    .rstActive (rstActive),
    .stepS     (syncIn[3]),
    .modeS     (syncIn[2]),
    .dirS      (syncIn[1]),
    .enS       (syncIn[0]),
    .posOdd    (posOdd),
    .st        (st)
  );

  sps_datapath u_dp (
    .clk    (clk),
    .st     (st),
    .posOdd (posOdd),
    .gates  (gates)
  );

  assign {gateA, gateAn, gateB, gateBn} = gates;
endmodule

// File: tb/stepper_phase_seq_bench.sv
module stepper_phase_seq_bench;
  logic clk = 1'b0;
  logic stepIn = 1'b0, modeHalf = 1'b0, dirCcw = 1'b0, rstN = 1'b0, runEn = 1'b0;
  logic gateA, gateAn, gateB, gateBn;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  stepper_phase_seq u_stepper_phase_seq (
    .clk(clk), .stepIn(stepIn), .modeHalf(modeHalf), .dirCcw(dirCcw),
    .rstN(rstN), .runEn(runEn),
    .gateA(gateA), .gateAn(gateAn), .gateB(gateB), .gateBn(gateBn)
  );

  // {half, reverse, expected gates}
  localparam int NV = 14;
  localparam logic [5:0] VEC [NV] = '{
    {1'b0, 1'b0, 4'b1010},  // R3 0->2
    {1'b0, 1'b0, 4'b0110},  // R3 2->4
    {1'b0, 1'b0, 4'b0101},  // R3 4->6
    {1'b0, 1'b0, 4'b1001},  // R5 6->0 wrap
    {1'b1, 1'b0, 4'b1000},  // R4 0->1
    {1'b1, 1'b0, 4'b1010},  // R4 1->2
    {1'b1, 1'b1, 4'b1000},  // R5 2->1 reverse
    {1'b0, 1'b1, 4'b1001},  // R6 odd, full reverse 1->0
    {1'b0, 1'b1, 4'b0101},  // R5 0->6 reverse wrap
    {1'b1, 1'b1, 4'b0100},  // R4 6->5
    {1'b0, 1'b0, 4'b0101},  // R6 odd, full forward 5->6
    {1'b1, 1'b0, 4'b0001},  // R2 6->7
    {1'b1, 1'b0, 4'b1001},  // R2 7->0 wrap
    {1'b1, 1'b1, 4'b0001}   // R5 0->7
  };

  function automatic logic [3:0] gatesNow();
    return {gateA, gateAn, gateB, gateBn};
  endfunction

  task automatic check(input string req, input logic [3:0] exp);
    checks++;
    if (gatesNow() !== exp) begin
      fails++;
      $display("FAIL %s: gates=%b expected=%b", req, gatesNow(), exp);
    end
    checks++;
    if ((gateA && gateAn) || (gateB && gateBn)) begin
      fails++;
      $display("FAIL R9: gates=%b expected no opposing pair", gatesNow());
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stepOnce(input logic half, input logic rev);
    @(negedge clk);
    modeHalf = half;
    dirCcw = rev;
    waitN(2);
    stepIn = 1'b1;
    waitN(4);
    stepIn = 1'b0;
    waitN(4);
  endtask

  initial begin
    logic [3:0] saved;
    waitN(1);
    check("R7 gates off in reset", 4'b0000);
    waitN(4);
    rstN = 1'b1;
    runEn = 1'b1;
    waitN(4);
    check("R7 home state after reset", 4'b1001);

    for (int i = 0; i < NV; i++) begin
      stepOnce(VEC[i][5], VEC[i][4]);
      check($sformatf("R1 R2 table vector %0d", i), VEC[i][3:0]);
    end

    // R1: three clock edges of latency, and no move while held high
    @(negedge clk);
    modeHalf = 1'b1; dirCcw = 1'b0;
    waitN(3);
    stepIn = 1'b1;
    waitN(2);
    check("R1 no change after two edges", 4'b0001);
    waitN(1);
    check("R1 moved after third edge", 4'b1001);
    waitN(20);
    check("R1 held high no extra move", 4'b1001);
    stepIn = 1'b0;
    waitN(6);
    check("R1 falling edge no move", 4'b1001);

    // R8: disable, step while disabled, resume
    stepOnce(1'b1, 1'b0);
    saved = gatesNow();
    check("R8 before disable", 4'b1000);
    runEn = 1'b0;
    waitN(2);
    check("R8 gates off when disabled", 4'b0000);
    stepOnce(1'b0, 1'b0);
    check("R8 step ignored while disabled", 4'b0000);
    runEn = 1'b1;
    waitN(4);
    check("R8 resume same state", saved);
    stepOnce(1'b0, 1'b0);
    check("R6 R8 odd full-step after resume", 4'b1010);

    // R7: reset mid-sequence
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R7 gates off at once", 4'b0000);
    waitN(4);
    rstN = 1'b1;
    waitN(4);
    check("R7 home after mid reset", 4'b1001);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule